// File: doc/BRIEF.md
# Counter Access Freeze Window

This block sits between the one-second square wave of a timekeeping prescaler and the chain of time counters. Normally, each falling edge of the one-second wave becomes a single one-clock tick that advances the chain. When the host begins a burst of register accesses late in the high half of the wave, the block defers the next tick by a quarter second. The host can then read or write the multi-byte time without a carry rippling through the counters partway through the burst.

The timing is measured in host clock cycles. A quarter second is `2**QTR_LOG2` cycles, and the bench shortens it. The arming window is the second quarter of the high half: the quarter second just before the falling edge. Once an edge is held, the host can let it go early by writing to the dedicated release index during the quarter second after the edge. Otherwise the edge goes out by itself when that quarter second ends. A write to the seconds index also produces a one-cycle request to clear the tail of the prescaler, which realigns the wave's phase.

Top module: `counter_freeze_gate`

## Requirements
- R1: With nothing held, every falling edge of `sec_wave_i` produces exactly one one-cycle pulse on `tick_o`, two clock edges after the input falls.
- R2: An access (`acc_stb_i` high, read or write) to any index other than 7 arms the freeze when it is made while the wave has been high for at least QTR cycles, counting from the cycle in which the rise is detected. The next falling edge then gives no tick at its normal time.
- R3: A held edge with no early release comes out as one `tick_o` pulse exactly QTR cycles later than an unheld tick would have come.
- R4: A write (`acc_wr_i` high) to index 1 while an edge is held gives a `tick_o` pulse on the next clock edge, and no further tick for that edge.
- R5: Accesses to index 7 never arm the freeze.
- R6: Accesses outside the arming window never arm the freeze: while the wave is low, or during the first QTR cycles of the high half. A write to index 1 has no effect while nothing is held, and neither does a read of index 1 while an edge is held.
- R7: The block releases exactly one tick for each falling edge. This also holds when a new falling edge arrives while an earlier one is still held. The held tick then goes out at once, and the new edge is held for a fresh quarter second.
- R8: A write to index 2 (seconds) pulses `presc_clr_o` for one cycle on the next clock edge. A read of index 2 or an access to any other index does not.
- R9: While `rst` is high, `tick_o` and `presc_clr_o` are low. A reset clears an armed or held freeze, so the first falling edge after reset gives a normal, undelayed tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_wave_i | input | 1 | One-second square wave from the prescaler, synchronous to `clk` |
| acc_stb_i | input | 1 | One-cycle strobe marking a host register access |
| acc_idx_i | input | 3 | Register index of the access |
| acc_wr_i | input | 1 | High for a write, low for a read |
| tick_o | output | 1 | One-cycle advance pulse for the time counter chain |
| presc_clr_o | output | 1 | One-cycle request to clear the prescaler tail |

## Verification
The assertions assume three things about the inputs. `sec_wave_i` is already synchronous to `clk`. Each half of the wave normally lasts at least two quarter-second spans. `acc_stb_i` marks one access per cycle. The stimulus drives the wave from a bench phase counter at the falling clock edge with a half period of exactly 2·QTR cycles. It breaks that rhythm only in one directed case, which forces an early second falling edge while a tick is held. Random bursts of accesses never fall in the last slot of a period, so every expected tick and prescaler-clear pulse falls inside the period that caused it.

// File: rtl/freeze_gate_pkg.sv
package freeze_gate_pkg;

    // Width of the host register index and the indices with special meaning.
    localparam int unsigned ACC_IDX_W   = 3;
    localparam int unsigned IDX_EXEMPT  = 7;
    localparam int unsigned IDX_RELEASE = 1;
    localparam int unsigned IDX_SECONDS = 2;

    typedef enum logic [1:0] {
        FG_IDLE  = 2'd0,
        FG_ARMED = 2'd1,
        FG_HELD  = 2'd2
    } fg_state_e;

    // Phase information derived from the one-second wave.
    typedef struct packed {
        logic fall;   // falling edge detected this cycle
        logic win_a;  // inside the arming window
    } ph_info_t;

    // Decoded host access.
    typedef struct packed {
        logic arm_qual;    // access that may arm the freeze
        logic release_wr;  // write to the release index
    } acc_req_t;

    function automatic logic idx_is(input logic [ACC_IDX_W-1:0] idx,
                                    input int unsigned          ref_idx);
        return idx == ACC_IDX_W'(ref_idx);
    endfunction

endpackage

// File: rtl/fg_phase_track.sv
module fg_phase_track
    import freeze_gate_pkg::*;
#(
    parameter int unsigned QTR_LOG2 = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wave_i,
    output ph_info_t ph_o
);
    localparam int unsigned CW  = QTR_LOG2 + 1;
    localparam int unsigned QTR = 1 << QTR_LOG2;

    logic          w_cur, w_prev;
    logic [CW-1:0] ph_cnt;
    logic          change;

    assign change = w_cur ^ w_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            w_cur  <= 1'b0;
            w_prev <= 1'b0;
            ph_cnt <= '0;
        end else begin
            w_cur  <= wave_i;
            w_prev <= w_cur;
            if (change)
                ph_cnt <= CW'(1);
            else if (ph_cnt != CW'(QTR))
                ph_cnt <= ph_cnt + CW'(1);
        end
    end

    always_comb begin
        ph_o.fall  = w_prev & ~w_cur;
        ph_o.win_a = w_cur & ~change & (ph_cnt == CW'(QTR));
    end

    // R1: a falling edge is reported for one cycle only
    assert_fall_single_R1: assert property (@(posedge clk) disable iff (rst)
        ph_o.fall |=> !ph_o.fall);

    // R6: the arming window never opens while the wave is low
    assert_window_high_only_R6: assert property (@(posedge clk) disable iff (rst)
        ph_o.win_a |-> w_cur);

endmodule

// File: rtl/fg_access_decode.sv
module fg_access_decode
    import freeze_gate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb_i,
    input  logic [ACC_IDX_W-1:0] idx_i,
    input  logic                 wr_i,
    output acc_req_t             req_o,
    output logic                 presc_clr_o
);
    logic sec_wr;

    always_comb begin
        req_o.arm_qual   = stb_i & ~idx_is(idx_i, IDX_EXEMPT);
        req_o.release_wr = stb_i & wr_i & idx_is(idx_i, IDX_RELEASE);
        sec_wr           = stb_i & wr_i & idx_is(idx_i, IDX_SECONDS);
    end

    always_ff @(posedge clk) begin
        if (rst) presc_clr_o <= 1'b0;
        else     presc_clr_o <= sec_wr;
    end

    // R8: a seconds write requests a prescaler clear on the next edge
    assert_sec_write_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (stb_i && wr_i && idx_i == ACC_IDX_W'(IDX_SECONDS)) |=> presc_clr_o);

    // R8: no other access requests a prescaler clear
    assert_no_stray_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !(stb_i && wr_i && idx_i == ACC_IDX_W'(IDX_SECONDS)) |=> !presc_clr_o);

endmodule

// File: rtl/fg_freeze_fsm.sv
module fg_freeze_fsm
    import freeze_gate_pkg::*;
#(
    parameter int unsigned QTR_LOG2 = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  ph_info_t  ph_i,
    input  acc_req_t  req_i,
    output logic      tick_o,
    output fg_state_e state_o
);
    localparam int unsigned CW  = QTR_LOG2 + 1;
    localparam int unsigned QTR = 1 << QTR_LOG2;

    fg_state_e     st, st_n;
    logic [CW-1:0] hold_cnt, hold_n;
    logic          tick_n;

    always_comb begin
        st_n   = st;
        hold_n = hold_cnt;
        tick_n = 1'b0;
        unique case (st)
            FG_IDLE: begin
                if (ph_i.fall)
                    tick_n = 1'b1;
                else if (req_i.arm_qual && ph_i.win_a)
                    st_n = FG_ARMED;
            end
            FG_ARMED: begin
                if (ph_i.fall) begin
                    st_n   = FG_HELD;
                    hold_n = CW'(1);
                end
            end
            FG_HELD: begin
                if (ph_i.fall) begin
                    // release the older edge now, hold the new one afresh
                    tick_n = 1'b1;
                    hold_n = CW'(1);
                end else if (req_i.release_wr || hold_cnt == CW'(QTR)) begin
                    tick_n = 1'b1;
                    st_n   = FG_IDLE;
                    hold_n = '0;
                end else begin
                    hold_n = hold_cnt + CW'(1);
                end
            end
            default: begin
                st_n   = FG_IDLE;
                hold_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FG_IDLE;
            hold_cnt <= '0;
            tick_o   <= 1'b0;
        end else begin
            st       <= st_n;
            hold_cnt <= hold_n;
            tick_o   <= tick_n;
        end
    end

    assign state_o = st;

    // R1: an unheld falling edge ticks on the next edge
    assert_idle_edge_ticks_R1: assert property (@(posedge clk) disable iff (rst)
        (st == FG_IDLE && ph_i.fall) |=> tick_o);

    // R2: an armed edge is held back
    assert_armed_edge_held_R2: assert property (@(posedge clk) disable iff (rst)
        (st == FG_ARMED && ph_i.fall) |=> (!tick_o && st == FG_HELD));

    // R3: the hold ends after a quarter second
    assert_hold_expires_R3: assert property (@(posedge clk) disable iff (rst)
        (st == FG_HELD && !ph_i.fall && hold_cnt == CW'(QTR)) |=> (tick_o && st == FG_IDLE));

    // R4: a release write lets the held tick out at once
    assert_release_write_R4: assert property (@(posedge clk) disable iff (rst)
        (st == FG_HELD && !ph_i.fall && req_i.release_wr) |=> (tick_o && st == FG_IDLE));

    // R7: a new edge while holding releases the old one and stays held
    assert_edge_while_held_R7: assert property (@(posedge clk) disable iff (rst)
        (st == FG_HELD && ph_i.fall) |=> (tick_o && st == FG_HELD));

    // R7: the hold count never passes a quarter second
    assert_hold_bounded_R7: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= CW'(QTR));

endmodule

// File: rtl/counter_freeze_gate.sv
module counter_freeze_gate
    import freeze_gate_pkg::*;
#(
    parameter int unsigned QTR_LOG2 = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_wave_i,
    input  logic                 acc_stb_i,
    input  logic [ACC_IDX_W-1:0] acc_idx_i,
    input  logic                 acc_wr_i,
    output logic                 tick_o,
    output logic                 presc_clr_o
);
    ph_info_t  ph;
    acc_req_t  req;
    fg_state_e fsm_state;

    fg_phase_track #(.QTR_LOG2(QTR_LOG2)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .wave_i (sec_wave_i),
        .ph_o   (ph)
    );

    fg_access_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .stb_i       (acc_stb_i),
        .idx_i       (acc_idx_i),
        .wr_i        (acc_wr_i),
        .req_o       (req),
        .presc_clr_o (presc_clr_o)
    );

    fg_freeze_fsm #(.QTR_LOG2(QTR_LOG2)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ph_i    (ph),
        .req_i   (req),
        .tick_o  (tick_o),
        .state_o (fsm_state)
    );

    // R5: accesses to the exempt index leave an idle gate idle
    assert_exempt_never_arms_R5: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == FG_IDLE && acc_stb_i && acc_idx_i == ACC_IDX_W'(IDX_EXEMPT))
        |=> fsm_state == FG_IDLE);

    // R6: accesses outside the arming window leave an idle gate idle
    assert_outside_window_R6: assert property (@(posedge clk) disable iff (rst)
        (fsm_state == FG_IDLE && acc_stb_i && !ph.win_a) |=> fsm_state == FG_IDLE);

endmodule

// File: tb/counter_freeze_gate_tb.sv
module counter_freeze_gate_tb;
    localparam int QL   = 4;
    localparam int QTR  = 1 << QL;
    localparam int HALF = 2 * QTR;
    localparam int PER  = 2 * HALF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_wave = 1'b0;
    logic       stb = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] idx = 3'd0;
    logic       tick;
    logic       clr;

    always #4 clk = ~clk;

    counter_freeze_gate #(.QTR_LOG2(QL)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .sec_wave_i  (sec_wave),
        .acc_stb_i   (stb),
        .acc_idx_i   (idx),
        .acc_wr_i    (wr),
        .tick_o      (tick),
        .presc_clr_o (clr)
    );

    int ph = 47;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    bit s_stb [PER];
    bit s_wr  [PER];
    int s_idx [PER];
    bit s_rst [PER];
    bit o_tick[PER];
    bit o_clr [PER];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One negedge: sample the outputs, then advance the phase and drive inputs.
    task automatic step(input bit b_stb, input int b_idx, input bit b_wr, input bit b_rst);
        @(negedge clk);
        ph = (ph + 1) % PER;
        o_tick[ph] = tick;
        o_clr[ph]  = clr;
        sec_wave   = (ph < HALF);
        stb        = b_stb;
        idx        = b_idx[2:0];
        wr         = b_wr;
        rst        = b_rst;
    endtask

    task automatic clear_sched();
        for (int p = 0; p < PER; p++) begin
            s_stb[p] = 1'b0; s_wr[p] = 1'b0; s_idx[p] = 0; s_rst[p] = 1'b0;
        end
    endtask

    // Expected phase at which the period's tick is seen, from the requirements.
    function automatic int exp_tick_ph();
        bit armed = 1'b0;
        bit rst_seen = 1'b0;
        for (int p = 0; p < PER; p++) if (s_rst[p] && p < HALF) rst_seen = 1'b1;
        for (int p = QTR + 1; p <= HALF; p++)
            if (s_stb[p] && s_idx[p] != 7 && !rst_seen) armed = 1'b1;  // R2 / R5
        for (int p = QTR + 1; p <= HALF; p++)
            if (s_rst[p]) armed = 1'b0;                                // R9
        if (!armed) return HALF + 2;                                   // R1
        for (int p = HALF + 2; p <= HALF + 1 + QTR; p++)
            if (s_stb[p] && s_wr[p] && s_idx[p] == 1) return p + 1;    // R4
        return HALF + 2 + QTR;                                         // R3
    endfunction

    task automatic run_period(input string req);
        int n_tick = 0;
        int first = -1;
        int exp_ph;
        int bad_clr = 0;
        bit e_clr;
        for (int p = 0; p < PER; p++) step(s_stb[p], s_idx[p], s_wr[p], s_rst[p]);
        exp_ph = exp_tick_ph();
        for (int p = 0; p < PER; p++) begin
            if (o_tick[p]) begin
                n_tick++;
                if (first < 0) first = p;
            end
            e_clr = (p > 0) && s_stb[p-1] && s_wr[p-1] && s_idx[p-1] == 2;
            if (o_clr[p] != e_clr) bad_clr++;
        end
        check(n_tick == 1 && first == exp_ph, req, "tick phase (count*100+phase)",
              n_tick * 100 + first, 100 + exp_ph);
        check(bad_clr == 0, "R8", "prescaler clear mismatches", bad_clr, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n_seq;
        void'($urandom(32'd20240611));

        // R9: reset state
        for (int k = 0; k < 16; k++) step(1'b0, 0, 1'b0, k < 8);
        check(o_tick[56] == 1'b0 && o_clr[56] == 1'b0, "R9", "outputs during reset",
              int'(o_tick[56]) + int'(o_clr[56]), 0);

        // R1: plain period
        clear_sched(); run_period("R1");
        // R5: exempt index inside the window
        clear_sched(); s_stb[20] = 1; s_idx[20] = 7; s_wr[20] = 1; run_period("R5");
        // R6: last slot before the window
        clear_sched(); s_stb[QTR] = 1; s_idx[QTR] = 3; run_period("R6");
        // R2 / R3: first slot of the window
        clear_sched(); s_stb[QTR+1] = 1; s_idx[QTR+1] = 3; run_period("R2");
        // R3: access in the last high slot
        clear_sched(); s_stb[HALF] = 1; s_idx[HALF] = 0; s_wr[HALF] = 1; run_period("R3");
        // R4: release write while held
        clear_sched(); s_stb[20] = 1; s_idx[20] = 4;
        s_stb[40] = 1; s_idx[40] = 1; s_wr[40] = 1; run_period("R4");
        // R6: release write before the edge is held has no effect
        clear_sched(); s_stb[20] = 1; s_idx[20] = 4;
        s_stb[HALF+1] = 1; s_idx[HALF+1] = 1; s_wr[HALF+1] = 1; run_period("R6");
        // R6: read of index 1 while held has no effect
        clear_sched(); s_stb[20] = 1; s_idx[20] = 4;
        s_stb[40] = 1; s_idx[40] = 1; run_period("R6");
        // R6: release write with nothing held, low-phase access
        clear_sched(); s_stb[40] = 1; s_idx[40] = 1; s_wr[40] = 1;
        s_stb[45] = 1; s_idx[45] = 3; run_period("R6");
        // R8: seconds write vs seconds read
        clear_sched(); s_stb[5] = 1; s_idx[5] = 2; s_wr[5] = 1;
        s_stb[10] = 1; s_idx[10] = 2; run_period("R8");
        // R9: reset while armed clears the freeze
        clear_sched(); s_stb[20] = 1; s_idx[20] = 3; s_rst[25] = 1; s_rst[26] = 1;
        run_period("R9");

        // R7: a second falling edge while an edge is held
        n_seq = 0;
        for (int p = 0; p <= 40; p++) begin
            step(p == 20, 3, 1'b0, 1'b0);
            n_seq += int'(o_tick[ph]);
        end
        ph = 28;
        while (ph != PER - 1) begin
            step(1'b0, 0, 1'b0, 1'b0);
            n_seq += int'(o_tick[ph]);
        end
        check(n_seq == 2, "R7", "ticks for two edges", n_seq, 2);

        // Random bursts, R1..R8 against the expectation function
        for (int r = 0; r < 250; r++) begin
            clear_sched();
            for (int p = 0; p < PER - 1; p++) begin
                if ($urandom % 6 == 0) begin
                    s_stb[p] = 1'b1;
                    s_idx[p] = int'($urandom % 8);
                    s_wr[p]  = 1'($urandom % 2);
                end
            end
            run_period("R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule